// File: doc/BRIEF.md
# Performance-Monitor Filter Register Access Trap Arbiter

This block decides what happens when software reads or writes the cycle-counter filter register of a performance monitor. It is purely combinational. Each cycle it looks at the system-register encoding of the access and the current privilege level, and at a set of control bits. These are the halted-debug and secure-debug-disable flags, a user-access enable, the hypervisor routing bits `tge` and `e2h`, fine-grained read and write trap bits, the level-2 and level-3 monitor trap bits, and an implementation option that moves the level-3 trap ahead of everything else. From these it reports whether the access is allowed, undefined, or trapped. A trap also reports a target level and an exception class.

The register can be reached in two ways: through its own encoding, or through the indirect event-type register when the counter select field is all ones. Any other encoding is not this block's access, and all result flags stay low. The register storage is outside this block. A surrounding access pipeline registers the verdict wherever it needs it. There is no streaming data path, so every pin is a plain level signal.

Top module: `pmf_trap_arbiter`

## Requirements
- R1: `hit` is 1 only when {op0,op1,crn,crm,op2} equals {2'b11,3'b011,4'b1110,4'b1111,3'b111}, or when it equals {2'b11,3'b011,4'b1001,4'b1101,3'b001} and `sel` equals 5'b11111. When `hit` is 0, `res_allow`, `res_undef` and `res_trap` are 0 and `tgt_lvl` and `exc_class` are 0.
- R2: At level 3 (`cur_lvl`=3) a hit access is always allowed.
- R3: At levels 0, 1 and 2 the first check gives undefined when `halted`, `sdd`, `imp_l3_first` and `l3_mon_trap` are all 1 and level 3 is implemented.
- R4: At level 0 with `user_en`=0 the access traps. The target is level 2 when `l2_enabled` and `tge` are both 1, and level 1 otherwise.
- R5: At levels 0 and 1 the fine-grained bit traps to level 2 when `l2_enabled` is 1 and either level 3 is absent or `l3_fgt_en` is 1. A read (`is_write`=0) uses `fgt_rd`; a write uses `fgt_wr`. At level 0 the check also requires {`e2h`,`tge`} to differ from 2'b11.
- R6: Next, at levels 0 and 1, `l2_mon_trap` traps to level 2 when `l2_enabled` is 1.
- R7: Last, at levels 0, 1 and 2, `l3_mon_trap` gives undefined if `halted` and `sdd` are both 1, and traps to level 3 otherwise.
- R8: Every trap reports `exc_class`=6'h18. Allowed and undefined results report 0 and `tgt_lvl`=0.
- R9: On a hit exactly one of `res_allow`, `res_undef` and `res_trap` is 1. The result is allow when no check fires.
- R10: With level 3 not implemented (`HAS_L3`=0), `l3_mon_trap` and `l3_fgt_en` have no effect and no trap targets level 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_lvl | input | 2 | Current privilege level |
| is_write | input | 1 | 1 for a write, 0 for a read |
| op0 | input | 2 | Encoding field op0 |
| op1 | input | 3 | Encoding field op1 |
| crn | input | 4 | Encoding field CRn |
| crm | input | 4 | Encoding field CRm |
| op2 | input | 3 | Encoding field op2 |
| sel | input | 5 | Counter select field for the indirect path |
| halted | input | 1 | Core is in halted debug state |
| sdd | input | 1 | Secure debug disabled |
| imp_l3_first | input | 1 | Implementation option: level-3 trap checked first |
| user_en | input | 1 | Level-0 access enable |
| l2_enabled | input | 1 | Level 2 is enabled in the current state |
| tge | input | 1 | Route level-0 exceptions to level 2 |
| e2h | input | 1 | Host extension at level 2 |
| fgt_rd | input | 1 | Fine-grained read trap bit |
| fgt_wr | input | 1 | Fine-grained write trap bit |
| l3_fgt_en | input | 1 | Level 3 enables fine-grained traps |
| l2_mon_trap | input | 1 | Level-2 monitor trap bit |
| l3_mon_trap | input | 1 | Level-3 monitor trap bit |
| hit | output | 1 | The access targets this register |
| res_allow | output | 1 | Access proceeds |
| res_undef | output | 1 | Access is undefined |
| res_trap | output | 1 | Access traps |
| tgt_lvl | output | 2 | Trap target level |
| exc_class | output | 6 | Exception class of the trap |

## Verification
The bench builds two copies side by side on the same inputs: one with `HAS_L3`=1 and one with `HAS_L3`=0. The first brings the early undefined check, the debug-gated level-3 outcome and the level-3 gate on the fine-grained check within reach. The second shows those conditions falling away, so the same stimulus gives a different verdict. Each scenario turns on several trap conditions at once, so that every step of the priority chain is seen to win over the steps after it.

// File: rtl/pmf_trap_pkg.sv
package pmf_trap_pkg;
  localparam int LVL_W = 2;
  localparam int EC_W  = 6;
  localparam logic [EC_W-1:0] EC_SYSREG = 6'h18;

  typedef enum logic [1:0] {
    VERDICT_ALLOW = 2'd0,
    VERDICT_UNDEF = 2'd1,
    VERDICT_TRAP  = 2'd2
  } verdict_e;

  typedef struct packed {
    logic [1:0] op0;
    logic [2:0] op1;
    logic [3:0] crn;
    logic [3:0] crm;
    logic [2:0] op2;
  } sysenc_t;
endpackage

// File: rtl/pmf_enc_match.sv
module pmf_enc_match
  import pmf_trap_pkg::*;
#(
  parameter sysenc_t DIRECT_ENC   = '{2'b11, 3'b011, 4'b1110, 4'b1111, 3'b111},
  parameter sysenc_t INDIRECT_ENC = '{2'b11, 3'b011, 4'b1001, 4'b1101, 3'b001},
  parameter int      SEL_W        = 5
) (
  input  sysenc_t          enc,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  localparam int NPATH = 2;
  localparam logic [SEL_W-1:0] SEL_ALIAS = {SEL_W{1'b1}};

  logic [NPATH-1:0] path_hit;

  // path 0 is the direct encoding, path 1 the indirect one qualified by sel
  for (genvar p = 0; p < NPATH; p++) begin : g_path
    if (p == 0) begin : g_direct
      assign path_hit[p] = (enc == DIRECT_ENC);
    end else begin : g_alias
      assign path_hit[p] = (enc == INDIRECT_ENC) && (sel == SEL_ALIAS);
    end
  end

  assign hit = |path_hit;
endmodule

// File: rtl/pmf_trap_chain.sv
module pmf_trap_chain
  import pmf_trap_pkg::*;
#(
  parameter bit HAS_L3 = 1'b1
) (
  input  logic [LVL_W-1:0] cur_lvl,
  input  logic             is_write,
  input  logic             halted,
  input  logic             sdd,
  input  logic             imp_l3_first,
  input  logic             user_en,
  input  logic             l2_enabled,
  input  logic             tge,
  input  logic             e2h,
  input  logic             fgt_rd,
  input  logic             fgt_wr,
  input  logic             l3_fgt_en,
  input  logic             l2_mon_trap,
  input  logic             l3_mon_trap,
  output verdict_e         verdict,
  output logic [LVL_W-1:0] tgt
);
  localparam logic L3 = HAS_L3 ? 1'b1 : 1'b0;

  logic early_undef, fgt_bit, fgt_gate, l2_mon, l3_mon, dbg_block;

  always_comb begin
    early_undef = halted & L3 & sdd & imp_l3_first & l3_mon_trap;
    fgt_bit     = is_write ? fgt_wr : fgt_rd;
    fgt_gate    = l2_enabled & (~L3 | l3_fgt_en) & fgt_bit;
    l2_mon      = l2_enabled & l2_mon_trap;
    l3_mon      = L3 & l3_mon_trap;
    dbg_block   = halted & sdd;
  end

  always_comb begin
    verdict = VERDICT_ALLOW;
    tgt     = '0;
    unique case (cur_lvl)
      2'd0: begin
        if (early_undef) verdict = VERDICT_UNDEF;
        else if (!user_en) begin
          verdict = VERDICT_TRAP;
          tgt     = (l2_enabled & tge) ? 2'd2 : 2'd1;
        end else if (fgt_gate && ({e2h, tge} != 2'b11)) begin
          verdict = VERDICT_TRAP;
          tgt     = 2'd2;
        end else if (l2_mon) begin
          verdict = VERDICT_TRAP;
          tgt     = 2'd2;
        end else if (l3_mon) begin
          if (dbg_block) verdict = VERDICT_UNDEF;
          else begin
            verdict = VERDICT_TRAP;
            tgt     = 2'd3;
          end
        end
      end
      2'd1: begin
        if (early_undef) verdict = VERDICT_UNDEF;
        else if (fgt_gate || l2_mon) begin
          verdict = VERDICT_TRAP;
          tgt     = 2'd2;
        end else if (l3_mon) begin
          if (dbg_block) verdict = VERDICT_UNDEF;
          else begin
            verdict = VERDICT_TRAP;
            tgt     = 2'd3;
          end
        end
      end
      2'd2: begin
        if (early_undef) verdict = VERDICT_UNDEF;
        else if (l3_mon) begin
          if (dbg_block) verdict = VERDICT_UNDEF;
          else begin
            verdict = VERDICT_TRAP;
            tgt     = 2'd3;
          end
        end
      end
      default: verdict = VERDICT_ALLOW;
    endcase
  end

  always_comb begin
    // R4 R5 R6 R7: a trap always goes to a higher level than the current one
    trap_up_chk: assert (verdict != VERDICT_TRAP || tgt > cur_lvl)
      else $error("trap target not above current level");
  end
endmodule

// File: rtl/pmf_trap_arbiter.sv
module pmf_trap_arbiter
  import pmf_trap_pkg::*;
#(
  parameter bit HAS_L3 = 1'b1,
  parameter int SEL_W  = 5
) (
  input  logic [1:0]       cur_lvl,
  input  logic             is_write,
  input  logic [1:0]       op0,
  input  logic [2:0]       op1,
  input  logic [3:0]       crn,
  input  logic [3:0]       crm,
  input  logic [2:0]       op2,
  input  logic [SEL_W-1:0] sel,
  input  logic             halted,
  input  logic             sdd,
  input  logic             imp_l3_first,
  input  logic             user_en,
  input  logic             l2_enabled,
  input  logic             tge,
  input  logic             e2h,
  input  logic             fgt_rd,
  input  logic             fgt_wr,
  input  logic             l3_fgt_en,
  input  logic             l2_mon_trap,
  input  logic             l3_mon_trap,
  output logic             hit,
  output logic             res_allow,
  output logic             res_undef,
  output logic             res_trap,
  output logic [1:0]       tgt_lvl,
  output logic [5:0]       exc_class
);
  sysenc_t          enc;
  verdict_e         verdict;
  logic [LVL_W-1:0] chain_tgt;

  assign enc = '{op0, op1, crn, crm, op2};

  pmf_enc_match #(.SEL_W(SEL_W)) u_match (
    .enc (enc),
    .sel (sel),
    .hit (hit)
  );

  pmf_trap_chain #(.HAS_L3(HAS_L3)) u_chain (
    .cur_lvl      (cur_lvl),
    .is_write     (is_write),
    .halted       (halted),
    .sdd          (sdd),
    .imp_l3_first (imp_l3_first),
    .user_en      (user_en),
    .l2_enabled   (l2_enabled),
    .tge          (tge),
    .e2h          (e2h),
    .fgt_rd       (fgt_rd),
    .fgt_wr       (fgt_wr),
    .l3_fgt_en    (l3_fgt_en),
    .l2_mon_trap  (l2_mon_trap),
    .l3_mon_trap  (l3_mon_trap),
    .verdict      (verdict),
    .tgt          (chain_tgt)
  );

  always_comb begin
    res_allow = hit && (verdict == VERDICT_ALLOW);
    res_undef = hit && (verdict == VERDICT_UNDEF);
    res_trap  = hit && (verdict == VERDICT_TRAP);
    tgt_lvl   = res_trap ? chain_tgt : '0;
    exc_class = res_trap ? EC_SYSREG : '0;
  end

  always_comb begin
    // R9
    one_verdict_chk: assert ($onehot0({res_allow, res_undef, res_trap}) &&
                             (hit == (res_allow | res_undef | res_trap)))
      else $error("result flags not one-hot on hit");
    // R8
    trap_class_chk: assert (!res_trap || (exc_class == 6'h18 && tgt_lvl != 2'd0))
      else $error("trap without class or target");
    // R2
    top_level_allow_chk: assert (!(hit && cur_lvl == 2'd3) || res_allow)
      else $error("level 3 access not allowed");
    // R10
    no_l3_target_chk: assert (HAS_L3 || tgt_lvl != 2'd3)
      else $error("trap to absent level 3");
  end
endmodule

// File: tb/pmf_trap_arbiter_bench.sv
`timescale 1ns/1ps
module pmf_trap_arbiter_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] cur_lvl;
  logic is_write;
  logic [1:0] op0; logic [2:0] op1; logic [3:0] crn, crm; logic [2:0] op2;
  logic [4:0] sel;
  logic halted, sdd, imp_l3_first, user_en, l2_enabled, tge, e2h;
  logic fgt_rd, fgt_wr, l3_fgt_en, l2_mon_trap, l3_mon_trap;

  logic a_hit, a_allow, a_undef, a_trap; logic [1:0] a_tgt; logic [5:0] a_ec;
  logic b_hit, b_allow, b_undef, b_trap; logic [1:0] b_tgt; logic [5:0] b_ec;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  pmf_trap_arbiter #(.HAS_L3(1'b1)) u_pmf_trap_arbiter (
    .cur_lvl, .is_write, .op0, .op1, .crn, .crm, .op2, .sel,
    .halted, .sdd, .imp_l3_first, .user_en, .l2_enabled, .tge, .e2h,
    .fgt_rd, .fgt_wr, .l3_fgt_en, .l2_mon_trap, .l3_mon_trap,
    .hit(a_hit), .res_allow(a_allow), .res_undef(a_undef), .res_trap(a_trap),
    .tgt_lvl(a_tgt), .exc_class(a_ec));

  pmf_trap_arbiter #(.HAS_L3(1'b0)) u_pmf_trap_arbiter_nol3 (
    .cur_lvl, .is_write, .op0, .op1, .crn, .crm, .op2, .sel,
    .halted, .sdd, .imp_l3_first, .user_en, .l2_enabled, .tge, .e2h,
    .fgt_rd, .fgt_wr, .l3_fgt_en, .l2_mon_trap, .l3_mon_trap,
    .hit(b_hit), .res_allow(b_allow), .res_undef(b_undef), .res_trap(b_trap),
    .tgt_lvl(b_tgt), .exc_class(b_ec));

  localparam logic [3:0] XA = 4'b1100; // hit, allow
  localparam logic [3:0] XU = 4'b1010; // hit, undef
  localparam logic [3:0] XT = 4'b1001; // hit, trap
  localparam logic [3:0] XN = 4'b0000; // no hit

  task automatic base(input logic [1:0] lvl);
    cur_lvl = lvl; is_write = 1'b0;
    op0 = 2'b11; op1 = 3'b011; crn = 4'b1110; crm = 4'b1111; op2 = 3'b111;
    sel = 5'd0; halted = 0; sdd = 0; imp_l3_first = 0; user_en = 1;
    l2_enabled = 0; tge = 0; e2h = 0; fgt_rd = 0; fgt_wr = 0;
    l3_fgt_en = 0; l2_mon_trap = 0; l3_mon_trap = 0;
  endtask

  task automatic expect_a(input string req, input logic [3:0] f, input logic [1:0] t);
    logic [11:0] act, exp;
    @(negedge clk);
    act = {a_hit, a_allow, a_undef, a_trap, a_tgt, a_ec};
    exp = {f, (f == XT) ? t : 2'd0, (f == XT) ? 6'h18 : 6'h00};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (L3 present): actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic expect_b(input string req, input logic [3:0] f, input logic [1:0] t);
    logic [11:0] act, exp;
    @(negedge clk);
    act = {b_hit, b_allow, b_undef, b_trap, b_tgt, b_ec};
    exp = {f, (f == XT) ? t : 2'd0, (f == XT) ? 6'h18 : 6'h00};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (L3 absent): actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic t_idle;
    base(2'd0); expect_a("R9 idle allow", XA, 0); expect_b("R9 idle allow", XA, 0);
    base(2'd1); expect_a("R9 idle allow L1", XA, 0);
    base(2'd2); expect_a("R9 idle allow L2", XA, 0);
  endtask

  task automatic t_decode;
    base(2'd0); crm = 4'b1110; l2_mon_trap = 1; l2_enabled = 1;
    expect_a("R1 wrong crm", XN, 0);
    base(2'd0); op2 = 3'b110; user_en = 0; expect_a("R1 wrong op2", XN, 0);
    base(2'd0); crn = 4'b1001; crm = 4'b1101; op2 = 3'b001; sel = 5'b11111;
    expect_a("R1 indirect alias", XA, 0);
    user_en = 0; expect_a("R1 indirect alias traps", XT, 1);
    sel = 5'b11110; expect_a("R1 alias wrong sel", XN, 0);
    base(2'd0); sel = 5'b11111; crm = 4'b1101; expect_a("R1 sel on direct mismatch", XN, 0);
  endtask

  task automatic t_top;
    base(2'd3); halted = 1; sdd = 1; imp_l3_first = 1; user_en = 0;
    l2_enabled = 1; fgt_rd = 1; fgt_wr = 1; l3_fgt_en = 1; l2_mon_trap = 1; l3_mon_trap = 1;
    expect_a("R2 level 3 allow", XA, 0); expect_b("R2 level 3 allow", XA, 0);
  endtask

  task automatic t_early;
    base(2'd0); halted = 1; sdd = 1; imp_l3_first = 1; l3_mon_trap = 1;
    user_en = 0; l2_enabled = 1; tge = 1;
    expect_a("R3 early undef beats user", XU, 0);
    expect_b("R10 early undef absent", XT, 2);
    base(2'd1); halted = 1; sdd = 1; imp_l3_first = 1; l3_mon_trap = 1;
    l2_enabled = 1; l2_mon_trap = 1; fgt_rd = 1; l3_fgt_en = 1;
    expect_a("R3 early undef beats fgt", XU, 0);
    imp_l3_first = 0; expect_a("R3 option off falls to fgt", XT, 2);
    base(2'd2); halted = 1; sdd = 1; imp_l3_first = 1; l3_mon_trap = 1;
    expect_a("R3 early undef L2", XU, 0);
  endtask

  task automatic t_user;
    base(2'd0); user_en = 0; expect_a("R4 user trap L1", XT, 1);
    l2_enabled = 1; tge = 1; l2_mon_trap = 1; l3_mon_trap = 1;
    expect_a("R4 user trap routed L2", XT, 2);
    l2_enabled = 0; expect_a("R4 tge without L2", XT, 1);
    l2_enabled = 1; tge = 0; expect_a("R4 L2 without tge", XT, 1);
  endtask

  task automatic t_fgt;
    base(2'd0); l2_enabled = 1; l3_fgt_en = 1; fgt_rd = 1; l3_mon_trap = 1;
    expect_a("R5 read fgt L0", XT, 2);
    is_write = 1; expect_a("R5 write ignores rd bit", XT, 3);
    fgt_wr = 1; expect_a("R5 write fgt", XT, 2);
    base(2'd0); l2_enabled = 1; l3_fgt_en = 1; fgt_rd = 1; e2h = 1; tge = 1;
    expect_a("R5 e2h tge 11 skips", XA, 0);
    e2h = 0; expect_a("R5 tge only traps", XT, 2);
    base(2'd1); l2_enabled = 1; l3_fgt_en = 1; fgt_rd = 1; e2h = 1; tge = 1;
    expect_a("R5 L1 ignores e2h tge", XT, 2);
    l3_fgt_en = 0; expect_a("R5 L3 gate closed", XA, 0);
    expect_b("R10 fgt without L3 gate", XT, 2);
    l3_fgt_en = 1; l2_enabled = 0; expect_a("R5 L2 disabled", XA, 0);
    base(2'd2); l2_enabled = 1; l3_fgt_en = 1; fgt_rd = 1;
    expect_a("R5 no fgt at L2", XA, 0);
  endtask

  task automatic t_l2mon;
    base(2'd1); l2_enabled = 1; l2_mon_trap = 1; l3_mon_trap = 1;
    expect_a("R6 L2 mon beats L3 mon", XT, 2);
    l2_enabled = 0; expect_a("R6 L2 disabled falls to L3", XT, 3);
    expect_b("R10 nothing left", XA, 0);
    base(2'd2); l2_enabled = 1; l2_mon_trap = 1; expect_a("R6 no effect at L2", XA, 0);
  endtask

  task automatic t_l3mon;
    base(2'd2); l3_mon_trap = 1; expect_a("R7 trap L3", XT, 3);
    expect_b("R10 L3 mon ignored", XA, 0);
    halted = 1; sdd = 1; expect_a("R7 halted sdd undef", XU, 0);
    sdd = 0; expect_a("R7 halted only traps", XT, 3);
    base(2'd0); l3_mon_trap = 1; halted = 1; sdd = 1;
    expect_a("R7 L0 undef", XU, 0);
    halted = 0; is_write = 1; expect_a("R7 L0 write trap", XT, 3);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    base(2'd0);
    repeat (2) @(posedge clk);
    t_idle;
    t_decode;
    t_top;
    t_early;
    t_user;
    t_fgt;
    t_l2mon;
    t_l3mon;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule